// File: doc/BRIEF.md
# Latched Add/Subtract Unit with Selectable Carry-In

This block is the arithmetic core of a small bus-based datapath. Two operand registers are filled one after another from a shared data bus. A single binary adder combines them. Operand B can be inverted on its way into the adder, and the carry-in comes from a four-way selector. With these two controls, one adder performs addition, two's-complement subtraction, add-with-carry and subtract-with-borrow, so values wider than the bus can be processed one byte at a time.

The adder output is captured in a result register when its load strobe is high. The carry, zero and negative flags are captured in a separate status register when its own load strobe is high. Either register can be placed on the shared bus through its own drive enable. Tri-state drive is modelled as a data value plus a valid strobe. When both enables are asserted together, the result register wins and a contention flag is raised.

All registers change only on a rising clock edge while their strobe is high, and a synchronous active-high reset clears every one of them.

Top module: `latched_alu`

## Requirements
- R1: A synchronous reset clears both operand registers, the result register and the status register to zero.
- R2: On a rising edge with `ld_opa` (or `ld_opb`) high, operand A (or B) takes the value of `din`. Otherwise it holds its value.
- R3: On a rising edge with `ld_res` high, the result register takes A + B' + cin modulo 256, computed from the operand values held before that edge. B' is B, or the bitwise complement of B when `inv_b` is 1. Without `ld_res` the result register holds its value.
- R4: `cin_sel` chooses the carry-in: 00 gives 0, 01 gives 1, 10 gives the stored carry flag, and 11 gives the complement of the stored carry flag.
- R5: With `inv_b`=1 and `cin_sel`=01 the unit computes A - B. The carry out is 1 when no borrow occurs (A >= B).
- R6: On a rising edge with `ld_stat` high, the status register captures three flags. Bit 0 is the adder carry out, bit 1 is set when the 8-bit sum is zero, and bit 2 is bit 7 of the sum. Without `ld_stat` the status register holds its value.
- R7: While `oe_stat` is high and `oe_res` is low, `dout` shows the status register in bits 2:0, with bits 7:3 reading 0.
- R8: `dout_vld` is high exactly when `oe_res` or `oe_stat` is high. When neither is high, `dout` is 0.
- R9: While `oe_res` is high, `dout` shows the result register. If `oe_stat` is also high, `bus_conflict` is 1; otherwise `bus_conflict` is 0.
- R10: Multi-byte arithmetic works by chaining bytes through the stored carry. `cin_sel`=10 with `inv_b`=0 adds the carry from the previous byte. `cin_sel`=10 with `inv_b`=1 subtracts with the previous byte's borrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Shared bus data into the operand registers |
| ld_opa | input | 1 | Load operand A from `din` |
| ld_opb | input | 1 | Load operand B from `din` |
| inv_b | input | 1 | Invert operand B at the adder input |
| cin_sel | input | 2 | Carry-in select (00 zero, 01 one, 10 C, 11 not-C) |
| ld_res | input | 1 | Capture the adder sum into the result register |
| ld_stat | input | 1 | Capture the flags into the status register |
| oe_res | input | 1 | Drive the result register onto the bus |
| oe_stat | input | 1 | Drive the status register onto the bus |
| dout | output | 8 | Bus value driven by the unit |
| dout_vld | output | 1 | High when the unit drives the bus |
| bus_conflict | output | 1 | Both drive enables are high in the same cycle |

## Verification
Several functions can fall in the same cycle: the two bus drivers can be enabled together, and an operand load can share an edge with a result or status capture. The directed part enables both drivers at once and expects the result value, a valid strobe and the conflict flag. The random part drives independent strobes, so loads, captures and both drive enables coincide often. A bench model updates every register from the values it held before the edge, and checks each cycle's bus output against that model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    parameter int unsigned DATA_W = 8;
    localparam int unsigned FLAG_W = 3;

    typedef enum logic [1:0] {
        CIN_ZERO   = 2'b00,
        CIN_ONE    = 2'b01,
        CIN_CARRY  = 2'b10,
        CIN_NCARRY = 2'b11
    } cin_sel_e;

    // packed MSB first: carry lands in bit 0, zero in bit 1, neg in bit 2
    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
    } flags_t;

    function automatic logic pick_cin(input cin_sel_e sel, input logic c);
        logic r;
        case (sel)
            CIN_ZERO:   r = 1'b0;
            CIN_ONE:    r = 1'b1;
            CIN_CARRY:  r = c;
            default:    r = ~c;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_latch.sv
module alu_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder
    import alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         inv_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output flags_t       flags
);
    logic [W-1:0] b_eff;
    logic [W:0]   total;

    always_comb begin
        b_eff       = inv_b ? ~b : b;
        total       = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum         = total[W-1:0];
        flags.carry = total[W];
        flags.zero  = (total[W-1:0] == '0);
        flags.neg   = total[W-1];
    end
endmodule

// File: rtl/alu_bus_mux.sv
module alu_bus_mux
    import alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] res,
    input  flags_t       stat,
    input  logic         oe_res,
    input  logic         oe_stat,
    output logic [W-1:0] dout,
    output logic         dout_vld,
    output logic         bus_conflict
);
    localparam int unsigned PAD_W = W - FLAG_W;

    always_comb begin
        if (oe_res)       dout = res;
        else if (oe_stat) dout = {{PAD_W{1'b0}}, stat};
        else              dout = '0;
        dout_vld     = oe_res | oe_stat;
        bus_conflict = oe_res & oe_stat;
    end
endmodule

// File: rtl/latched_alu.sv
module latched_alu
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              ld_opa,
    input  logic              ld_opb,
    input  logic              inv_b,
    input  logic [1:0]        cin_sel,
    input  logic              ld_res,
    input  logic              ld_stat,
    input  logic              oe_res,
    input  logic              oe_stat,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              bus_conflict
);
    logic [DATA_W-1:0] opa_q, opb_q, res_q, sum;
    logic [FLAG_W-1:0] stat_raw;
    flags_t            stat_q, new_flags;
    logic              cin;

    alu_latch #(.W(DATA_W)) u_opa (
        .clk(clk), .rst(rst), .load(ld_opa), .d(din), .q(opa_q));
    alu_latch #(.W(DATA_W)) u_opb (
        .clk(clk), .rst(rst), .load(ld_opb), .d(din), .q(opb_q));

    assign cin = pick_cin(cin_sel_e'(cin_sel), stat_q.carry);

    alu_adder #(.W(DATA_W)) u_add (
        .a(opa_q), .b(opb_q), .inv_b(inv_b), .cin(cin),
        .sum(sum), .flags(new_flags));

    alu_latch #(.W(DATA_W)) u_res (
        .clk(clk), .rst(rst), .load(ld_res), .d(sum), .q(res_q));
    alu_latch #(.W(FLAG_W)) u_stat (
        .clk(clk), .rst(rst), .load(ld_stat), .d(new_flags), .q(stat_raw));

    assign stat_q = flags_t'(stat_raw);

    alu_bus_mux #(.W(DATA_W)) u_bus (
        .res(res_q), .stat(stat_q), .oe_res(oe_res), .oe_stat(oe_stat),
        .dout(dout), .dout_vld(dout_vld), .bus_conflict(bus_conflict));
endmodule

// File: rtl/latched_alu_chk.sv
module latched_alu_chk
    import alu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] din,
    input logic              ld_opa,
    input logic              ld_res,
    input logic              ld_stat,
    input logic              oe_res,
    input logic              oe_stat,
    input logic [DATA_W-1:0] opa_q,
    input logic [DATA_W-1:0] res_q,
    input logic [DATA_W-1:0] sum,
    input logic [2:0]        stat_raw,
    input logic [DATA_W-1:0] dout,
    input logic              dout_vld,
    input logic              bus_conflict
);
    // R2
    opa_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld_opa |=> opa_q == $past(din));
    // R3
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_res |=> $stable(res_q));
    // R6
    stat_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ld_stat |=> stat_raw[1] == ($past(sum) == '0));
    // R7
    stat_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_stat && !oe_res) |-> dout[DATA_W-1:3] == '0);
    // R8
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !(oe_res || oe_stat) |-> (!dout_vld && dout == '0));
    // R9
    res_prio_chk: assert property (@(posedge clk) disable iff (rst)
        oe_res |-> (dout == res_q && dout_vld));
    // R9
    conflict_chk: assert property (@(posedge clk) disable iff (rst)
        bus_conflict |-> (oe_res && oe_stat));
endmodule

bind latched_alu latched_alu_chk u_chk (
    .clk(clk), .rst(rst), .din(din), .ld_opa(ld_opa), .ld_res(ld_res),
    .ld_stat(ld_stat), .oe_res(oe_res), .oe_stat(oe_stat), .opa_q(opa_q),
    .res_q(res_q), .sum(sum), .stat_raw(stat_raw), .dout(dout),
    .dout_vld(dout_vld), .bus_conflict(bus_conflict));

// File: tb/sim_latched_alu.sv
module sim_latched_alu;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] din;
    logic       ld_opa, ld_opb, inv_b, ld_res, ld_stat, oe_res, oe_stat;
    logic [1:0] cin_sel;
    logic [7:0] dout;
    logic       dout_vld, bus_conflict;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] m_a, m_b, m_res;
    logic [2:0] m_stat;

    always #5 clk = ~clk;

    latched_alu u0 (
        .clk(clk), .rst(rst), .din(din), .ld_opa(ld_opa), .ld_opb(ld_opb),
        .inv_b(inv_b), .cin_sel(cin_sel), .ld_res(ld_res), .ld_stat(ld_stat),
        .oe_res(oe_res), .oe_stat(oe_stat), .dout(dout), .dout_vld(dout_vld),
        .bus_conflict(bus_conflict));

    function automatic logic [8:0] ref_add(input logic [7:0] a, input logic [7:0] b,
                                           input logic inv, input logic [1:0] sel,
                                           input logic c);
        logic       ci;
        logic [7:0] bb;
        bb = inv ? ~b : b;
        case (sel)
            2'b00: ci = 1'b0;
            2'b01: ci = 1'b1;
            2'b10: ci = c;
            default: ci = ~c;
        endcase
        return {1'b0, a} + {1'b0, bb} + {8'd0, ci};
    endfunction

    task automatic compare(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] d, input logic la, input logic lb,
                        input logic inv, input logic [1:0] cs, input logic lr,
                        input logic ls, input logic dr, input logic ds,
                        input string tag);
        logic [8:0] s;
        logic [7:0] e_out;
        din = d; ld_opa = la; ld_opb = lb; inv_b = inv; cin_sel = cs;
        ld_res = lr; ld_stat = ls; oe_res = dr; oe_stat = ds;
        #4;
        e_out = dr ? m_res : (ds ? {5'd0, m_stat} : 8'h00);
        compare(dout, e_out, tag);
        compare({7'd0, dout_vld}, {7'd0, dr | ds}, tag);
        compare({7'd0, bus_conflict}, {7'd0, dr & ds}, tag);
        @(posedge clk);
        s = ref_add(m_a, m_b, inv, cs, m_stat[0]);
        if (lr) m_res = s[7:0];
        if (ls) m_stat = {s[7], s[7:0] == 8'h00, s[8]};
        if (la) m_a = d;
        if (lb) m_b = d;
        @(negedge clk);
    endtask

    // load A and B, then capture result and status with the given controls
    task automatic calc(input logic [7:0] a, input logic [7:0] b, input logic inv,
                        input logic [1:0] cs, input string tag);
        step(a, 1, 0, 0, 2'b00, 0, 0, 0, 0, tag);
        step(b, 0, 1, 0, 2'b00, 0, 0, 0, 0, tag);
        step(8'h00, 0, 0, inv, cs, 1, 1, 0, 0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; din = 8'h5A; ld_opa = 1; ld_opb = 1; inv_b = 0; cin_sel = 2'b01;
        ld_res = 1; ld_stat = 1; oe_res = 0; oe_stat = 0;
        m_a = 0; m_b = 0; m_res = 0; m_stat = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything cleared after reset
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 1, 0, "R1");
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 0, 1, "R1");
        step(8'h00, 0, 0, 0, 2'b00, 1, 0, 0, 0, "R1"); // sum of cleared operands
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 1, 0, "R1");

        // R2: operand loads, then 3C + 11
        calc(8'h3C, 8'h11, 0, 2'b00, "R2");
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 1, 0, "R2");
        compare(dout, 8'h4D, "R2");
        // R3: result holds while bus data and operands change
        step(8'hAA, 1, 1, 0, 2'b00, 0, 0, 1, 0, "R3");
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 1, 0, "R3");
        compare(dout, 8'h4D, "R3");

        // R6: FF + 01 -> 00, zero and carry set
        calc(8'hFF, 8'h01, 0, 2'b00, "R6");
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 0, 1, "R6");
        compare(dout, 8'h03, "R6");

        // R5: 05 - 07 -> FE, negative, borrow (carry 0)
        calc(8'h05, 8'h07, 1, 2'b01, "R5");
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 1, 0, "R5");
        compare(dout, 8'hFE, "R5");
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 0, 1, "R5");
        compare(dout, 8'h04, "R5");
        calc(8'h09, 8'h09, 1, 2'b01, "R5");
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 0, 1, "R5");
        compare(dout, 8'h03, "R5");

        // R4: carry-in choices, stored carry currently 1
        calc(8'h10, 8'h20, 0, 2'b11, "R4");   // not-C = 0 -> 30, C now 0
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 1, 0, "R4");
        compare(dout, 8'h30, "R4");
        calc(8'h10, 8'h20, 0, 2'b11, "R4");   // not-C = 1 -> 31
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 1, 0, "R4");
        compare(dout, 8'h31, "R4");

        // R10: 01FF + 0001 = 0200 via stored carry
        calc(8'hFF, 8'h01, 0, 2'b00, "R10");
        calc(8'h01, 8'h00, 0, 2'b10, "R10");
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 1, 0, "R10");
        compare(dout, 8'h02, "R10");
        // R10: 0100 - 0001 = 00FF via stored borrow
        calc(8'h00, 8'h01, 1, 2'b01, "R10");
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 1, 0, "R10");
        compare(dout, 8'hFF, "R10");
        calc(8'h01, 8'h00, 1, 2'b10, "R10");
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 1, 0, "R10");
        compare(dout, 8'h00, "R10");

        // R9 / R7 / R8: drive combinations
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 1, 1, "R9");
        compare({7'd0, bus_conflict}, 8'h01, "R9");
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 0, 1, "R7");
        step(8'h00, 0, 0, 0, 2'b00, 0, 0, 0, 0, "R8");

        // random phase
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] r;
            logic dr, ds;
            string tg;
            r  = 4'($urandom);
            dr = ($urandom % 3) == 0;
            ds = ($urandom % 3) == 0;
            tg = dr ? (ds ? "R9" : "R3") : (ds ? "R7" : "R8");
            step(8'($urandom), r[0], r[1], r[2], 2'($urandom),
                 r[3], ($urandom % 2) == 0, dr, ds, tg);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule